// File: doc/BRIEF.md
# Interrupt acknowledge and return sequencer

This block sits on the processor side of a vectored interrupt system. It runs the bus cycles that fetch an interrupt vector and the cycles that signal the end of a service routine. A start strobe selects one of two sequences. The first is an acknowledge, which obtains a vector. The second is a return, which tells the interrupt controllers that service has finished.

An acknowledge begins with a master acknowledge cycle, and the low byte read in that cycle is examined. A byte with its top bit clear is the final vector. A byte with its top bit set is a negative index into a table that grows downward from the interrupt base register. The sequencer reads a 32-bit cascade address from that table and then runs a cascaded acknowledge cycle at that address. The low byte of that cycle is the final vector, read as unsigned.

A return follows the same pattern with end-of-interrupt cycles. The byte from the cascaded end-of-interrupt cycle is thrown away. Each bus cycle is a request held until ready. The cycle type travels as a code beside the address. At the end of every sequence the done strobe pulses with the vector and a flag that tells an acknowledge from a return.

Top module: `irq_seq`

## Requirements
- R1: After reset, bus_req_o and done_o are low. No bus cycle starts until start_i is seen.
- R2: A sequence begins with one master cycle at address 0. Its type code is 0 for an acknowledge (ret_i=0 at start) and 2 for a return (ret_i=1).
- R3: In an acknowledge, if bit 7 of the master byte (bus_rdata_i[7:0]) is 0, no further cycle runs. done_o then pulses with done_vec_o equal to that byte and done_ret_o=0. Bits above 7 of the read data are ignored.
- R4: If bit 7 of the master byte is 1, the next cycle is a memory read with type code 4. Its address is int_base_i minus 4*(256 - byte), modulo 2^32.
- R5: In an acknowledge, the full 32-bit word from the memory read becomes the address of a cascaded acknowledge cycle with type code 1. The low byte of that cycle, read as unsigned, is output on done_vec_o with done_ret_o=0.
- R6: In a return whose master byte has bit 7 clear, no further cycle runs. done_o pulses with done_ret_o=1 and done_vec_o=0, whatever bits 6..0 hold.
- R7: In a return whose master byte has bit 7 set, the memory read of R4 is followed by a cascaded end-of-interrupt cycle with type code 3 at the fetched address. That cycle's byte is discarded: done_vec_o=0 and done_ret_o=1.
- R8: A start_i pulse that arrives while a sequence is in progress is ignored. It does not change the cycles that run, the mode, or the number of done pulses.
- R9: done_o is high for exactly one clock per sequence, in the cycle after the ready of the last bus cycle. bus_req_o is low in that cycle.
- R10: While bus_req_o is high and bus_rdy_i is low, the request, type and address stay unchanged into the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled only when idle |
| ret_i | input | 1 | 0 = acknowledge sequence, 1 = return sequence |
| int_base_i | input | W | Interrupt base register value |
| bus_req_o | output | 1 | Bus cycle request |
| bus_type_o | output | 3 | Cycle type code (0..4) |
| bus_addr_o | output | W | Cycle address |
| bus_rdy_i | input | 1 | Cycle completes at this clock edge |
| bus_rdata_i | input | W | Read data, valid with bus_rdy_i |
| done_o | output | 1 | One-clock completion strobe |
| done_ret_o | output | 1 | Completed sequence was a return |
| done_vec_o | output | 8 | Final vector (0 for returns) |

## Verification
A wrong sequencer state shows up on the bus port within one cycle. It appears as a missing or extra memory read, a wrong type code, or a cascaded cycle aimed at an address other than the fetched word. A corrupt latched table address or cascade address is visible at the next ready of that phase. A wrong mode flag shows the following cycle as a mismatched end-of-interrupt or acknowledge code. A wrong completion decision shows in the done strobe one clock after the final ready, either as a lost pulse, a double pulse, or a vector that differs from the byte the arithmetic predicts.

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         ret_i,
  input  logic [W-1:0] int_base_i,
  output logic         bus_req_o,
  output logic [2:0]   bus_type_o,
  output logic [W-1:0] bus_addr_o,
  input  logic         bus_rdy_i,
  input  logic [W-1:0] bus_rdata_i,
  output logic         done_o,
  output logic         done_ret_o,
  output logic [7:0]   done_vec_o
);

  localparam logic [2:0] T_ACK_M = 3'd0;
  localparam logic [2:0] T_ACK_C = 3'd1;
  localparam logic [2:0] T_EOI_M = 3'd2;
  localparam logic [2:0] T_EOI_C = 3'd3;
  localparam logic [2:0] T_MEM   = 3'd4;
  localparam int         EXT_W   = W - 10;

  typedef enum logic [1:0] {S_IDLE, S_MASTER, S_TABLE, S_CASC} st_t;

  st_t          st;
  logic         ret_q;
  logic [W-1:0] tbl_q;
  logic [W-1:0] casc_q;

  wire [7:0]   rbyte = bus_rdata_i[7:0];
  wire [W-1:0] offs  = {{EXT_W{rbyte[7]}}, rbyte, 2'b00};
  wire         fin   = bus_rdy_i && ((st == S_MASTER && !rbyte[7]) || st == S_CASC);

  assign bus_req_o = (st != S_IDLE);

  always_comb begin
    case (st)
      S_MASTER: begin bus_type_o = ret_q ? T_EOI_M : T_ACK_M; bus_addr_o = '0;     end
      S_TABLE:  begin bus_type_o = T_MEM;                     bus_addr_o = tbl_q;  end
      S_CASC:   begin bus_type_o = ret_q ? T_EOI_C : T_ACK_C; bus_addr_o = casc_q; end
      default:  begin bus_type_o = T_ACK_M;                   bus_addr_o = '0;     end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ret_q      <= 1'b0;
      tbl_q      <= '0;
      casc_q     <= '0;
      done_o     <= 1'b0;
      done_ret_o <= 1'b0;
      done_vec_o <= '0;
    end else begin
      done_o <= fin;
      if (fin) begin
        done_ret_o <= ret_q;
        done_vec_o <= ret_q ? 8'd0 : rbyte;
      end
      case (st)
        S_IDLE: if (start_i) begin
          ret_q <= ret_i;
          st    <= S_MASTER;
        end
        S_MASTER: if (bus_rdy_i) begin
          if (rbyte[7]) begin
            tbl_q <= int_base_i + offs;
            st    <= S_TABLE;
          end else begin
            st <= S_IDLE;
          end
        end
        S_TABLE: if (bus_rdy_i) begin
          casc_q <= bus_rdata_i;
          st     <= S_CASC;
        end
        S_CASC: if (bus_rdy_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_rdy_i |=> bus_req_o && $stable(bus_type_o) && $stable(bus_addr_o));

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_idle_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !bus_req_o);

  assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> bus_type_o <= T_MEM);

  assert_ret_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && done_ret_o |-> done_vec_o == 8'd0);

  assert_casc_after_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && bus_rdy_i && bus_type_o == T_MEM |=> bus_req_o && (bus_type_o == T_ACK_C || bus_type_o == T_EOI_C));

endmodule

// File: tb/irq_seq_bench.sv
module irq_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        ret_i = 1'b0;
  logic [31:0] int_base_i = '0;
  logic        bus_req_o;
  logic [2:0]  bus_type_o;
  logic [31:0] bus_addr_o;
  logic        bus_rdy_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;
  logic        done_o;
  logic        done_ret_o;
  logic [7:0]  done_vec_o;

  always #2 clk = ~clk;

  irq_seq u_irq_seq (.*);

  int total = 0;
  int bad = 0;

  logic [7:0]  m_byte;
  logic [31:0] t_word;
  logic [7:0]  c_byte;
  int          wait_n = 0;
  int          wcnt = 0;
  int          cyc_n = 0;
  int          stab_bad = 0;
  logic [2:0]  log_t [0:7];
  logic [31:0] log_a [0:7];
  logic [2:0]  first_t;
  logic [31:0] first_a;

  always @(negedge clk) begin
    bus_rdy_i = 1'b0;
    if (rst_n && bus_req_o) begin
      if (wcnt == 0) begin
        first_t = bus_type_o;
        first_a = bus_addr_o;
      end else if (bus_type_o != first_t || bus_addr_o != first_a) begin
        stab_bad++;
      end
      if (wcnt >= wait_n) begin
        if (cyc_n < 8) begin
          log_t[cyc_n] = bus_type_o;
          log_a[cyc_n] = bus_addr_o;
        end
        cyc_n++;
        case (bus_type_o)
          3'd4:       bus_rdata_i = t_word;
          3'd1, 3'd3: bus_rdata_i = {24'h5A3C96, c_byte};
          default:    bus_rdata_i = {24'hFFE781, m_byte};
        endcase
        bus_rdy_i = 1'b1;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_seq(input bit ret, input logic [7:0] mb, input logic [31:0] base,
                         input logic [31:0] tw, input logic [7:0] cb, input int wt, input bit inj);
    logic [31:0] exp_tbl;
    logic [7:0]  exp_vec;
    int          dones;
    int          exp_n;
    bit          got;
    m_byte = mb; t_word = tw; c_byte = cb; wait_n = wt;
    cyc_n = 0; stab_bad = 0; wcnt = 0; dones = 0;
    int_base_i = base;
    exp_tbl = base - 32'((256 - int'(mb)) * 4);
    exp_n   = mb[7] ? 3 : 1;
    exp_vec = ret ? 8'd0 : (mb[7] ? cb : mb);
    @(negedge clk);
    start_i = 1'b1; ret_i = ret;
    @(negedge clk);
    start_i = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (k == 0 && inj) begin start_i = 1'b1; ret_i = ~ret; end
      if (k == 1) start_i = 1'b0;
      if (done_o) begin
        dones++;
        if (!got) begin
          got = 1'b1;
          check(!bus_req_o, "R9", "req during done", 32'(bus_req_o), 0);
          check(done_ret_o == ret, ret ? "R6" : "R3", "done_ret", 32'(done_ret_o), 32'(ret));
          check(done_vec_o == exp_vec,
                ret ? (mb[7] ? "R7" : "R6") : (mb[7] ? "R5" : "R3"),
                "vector", 32'(done_vec_o), 32'(exp_vec));
        end
      end
      if (got && k > 8) break;
      @(negedge clk);
    end
    start_i = 1'b0;
    check(got, "R9", "done seen", 32'(got), 1);
    check(dones == 1, inj ? "R8" : "R9", "done count", 32'(dones), 1);
    check(cyc_n == exp_n, inj ? "R8" : (mb[7] ? "R4" : "R3"), "cycle count", 32'(cyc_n), 32'(exp_n));
    check(stab_bad == 0, "R10", "request held", 32'(stab_bad), 0);
    if (cyc_n >= 1) begin
      check(log_t[0] == (ret ? 3'd2 : 3'd0), "R2", "master type", 32'(log_t[0]), ret ? 2 : 0);
      check(log_a[0] == 0, "R2", "master addr", log_a[0], 0);
    end
    if (mb[7] && cyc_n >= 3) begin
      check(log_t[1] == 3'd4, "R4", "table type", 32'(log_t[1]), 4);
      check(log_a[1] == exp_tbl, "R4", "table addr", log_a[1], exp_tbl);
      check(log_t[2] == (ret ? 3'd3 : 3'd1), ret ? "R7" : "R5", "casc type", 32'(log_t[2]), ret ? 3 : 1);
      check(log_a[2] == tw, ret ? "R7" : "R5", "casc addr", log_a[2], tw);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!bus_req_o && !done_o, "R1", "reset outputs", {30'd0, bus_req_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!bus_req_o && cyc_n == 0, "R1", "idle without start", 32'(cyc_n), 0);
    for (int i = 0; i < 256; i++) begin
      for (int r = 0; r < 2; r++) begin
        run_seq(r[0], 8'(i), 32'h0000_0100 + 32'(i) * 32'h0101_0007,
                32'h1000_0000 + 32'(i) * 16 + 32'(r), 8'(i) ^ 8'hA5, (i + r) % 3, (i % 5) == 0);
      end
    end
    run_seq(1'b0, 8'h80, 32'h0, 32'hDEAD_BEE0, 8'hFF, 0, 1'b0);
    run_seq(1'b0, 8'hFF, 32'h0, 32'hCAFE_0004, 8'h80, 4, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog actual=%h expected=%h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule